// File: doc/BRIEF.md
# Busbar Differential Saturation Detector with Adaptive Trip Supervision

This block sits after the percent-differential stage of a low-impedance busbar protection. It watches the operating point (differential magnitude against restraint magnitude) one sample at a time. From that point it decides whether an external fault, possibly with current-transformer saturation, is in progress. The decision is held in a three-state machine with seal-in. The block then chooses how much supervision the restrained differential pickup needs before it may trip.

Supervision is one of two kinds. In 1-out-of-2 operation the restrained pickup trips by itself. In 2-out-of-2 operation it also needs the directional (phase-comparison) permission, which arrives as an input. Low-restraint operation (Region 1) always uses 2-out-of-2. High-restraint operation (Region 2) uses 1-out-of-2 unless the saturation flag is set. The saturation flag never blocks a trip outright. The unrestrained operate flag bypasses all supervision.

A strobe marks each new sample. All outputs are registered and update on the clock edge that takes a strobed sample. Between strobes the outputs hold.

Top module: `busdiff_satsup`

## Requirements
- R1: While reset is active and after it is released, the outputs are `state_o`=0, `sat_flag`=0, `trip`=0 and `mode_2oo2`=1. State codes are 0 for no fault, 1 for external fault and 2 for external fault with saturation.
- R2: The machine moves from state 0 to state 1 on a strobed sample when both of these hold: `rest_mag` > `high_bkpt`, and `diff_mag`*2^SW < `rest_mag`*`low_slope`. The slope is a fraction in units of 2^-SW. `sat_flag` reads 1 in states 1 and 2.
- R3: If `rest_mag` <= `high_bkpt`, or `diff_mag`*2^SW >= `rest_mag`*`low_slope`, the machine stays in state 0 unless `didt_flag` is set. Equality counts as "not below the line".
- R4: A strobed sample with `didt_flag`=1 moves state 0 to state 1 whatever the operating point.
- R5: In state 1, a strobed sample with `biased_pkp`=1 moves the machine to state 2.
- R6: From state 1 or 2 the machine returns to state 0 after N consecutive strobed samples with `biased_pkp`=0, where N = `ret_count`. A value of 0 is taken as 1. A sample with `biased_pkp`=1 restarts the count.
- R7: When `rest_mag` <= `high_bkpt` (Region 1), `mode_2oo2`=1. A restrained trip then needs both `biased_pkp` and `dir_ok`.
- R8: When `rest_mag` > `high_bkpt` (Region 2) and the state after the sample is 0, `mode_2oo2`=0. `biased_pkp` alone then sets `trip`.
- R9: When the state after the sample is 1 or 2, `mode_2oo2`=1 and `biased_pkp` with `dir_ok` still trips. Saturation never blocks the differential.
- R10: A strobed sample with `unbiased_op`=1 sets `trip`, whatever the state, region or direction.
- R11: With `sample_vld`=0, `state_o`, `sat_flag`, `mode_2oo2` and `trip` keep their values whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_vld | input | 1 | Strobe: a new sample is present on the inputs |
| diff_mag | input | W | Differential current magnitude |
| rest_mag | input | W | Restraint current magnitude |
| low_slope | input | SW | Low slope as a fraction of 2^SW |
| high_bkpt | input | W | High breakpoint on the restraint axis |
| ret_count | input | TW | Samples outside the characteristic needed to return to state 0 |
| biased_pkp | input | 1 | Restrained differential pickup (operating point inside the characteristic) |
| unbiased_op | input | 1 | Unrestrained differential operate |
| didt_flag | input | 1 | Sample-level restraint-derivative saturation indication |
| dir_ok | input | 1 | Directional phase-comparison permission |
| state_o | output | 2 | Detector state code |
| sat_flag | output | 1 | Saturation / external-fault flag |
| mode_2oo2 | output | 1 | 1 when 2-out-of-2 supervision applies |
| trip | output | 1 | Supervised differential trip |

## Verification
The bench targets four edges of the operating point:
- restraint exactly at the breakpoint, and differential exactly on the slope line; an off-by-one comparator would enter the external-fault state at these points;
- a pickup that arrives partway through the return timer; a timer that does not restart would drop the seal-in early;
- a return count of zero; it must act as one sample and must not wrap to a very long hold;
- a pickup in Region 2 after saturation, with and without permission; a design that blocks on saturation would never trip, and one that ignores the flag would trip without direction.

It also changes inputs while the strobe is low. A design that updates without a strobe would move its outputs there.

// File: rtl/busdiff_pkg.sv
`timescale 1ns/1ps
package busdiff_pkg;

  typedef enum logic [1:0] {
    ST_NORMAL = 2'd0,
    ST_EXTF   = 2'd1,
    ST_EXTSAT = 2'd2
  } sat_state_e;

  // Saturation flag implied by a state code
  function automatic logic sat_of(input sat_state_e s);
    return (s != ST_NORMAL);
  endfunction

endpackage

// File: rtl/busdiff_opzone.sv
`timescale 1ns/1ps
// Operating-point classification: region and slope-line comparison
module busdiff_opzone #(
  parameter int W  = 16,
  parameter int SW = 8
) (
  input  logic [W-1:0]  diff_mag,
  input  logic [W-1:0]  rest_mag,
  input  logic [SW-1:0] low_slope,
  input  logic [W-1:0]  high_bkpt,
  output logic          region2,
  output logic          under_line,
  output logic          phasor_entry
);
  localparam int PW = W + SW;

  // diff * 2^SW strictly below rest * slope
  function automatic logic below_slope(input logic [W-1:0] d,
                                       input logic [W-1:0] r,
                                       input logic [SW-1:0] s);
    logic [PW-1:0] lhs;
    logic [PW-1:0] rhs;
    lhs = PW'(d) << SW;
    rhs = PW'(r) * PW'(s);
    return lhs < rhs;
  endfunction

  always_comb begin
    region2      = rest_mag > high_bkpt;
    under_line   = below_slope(diff_mag, rest_mag, low_slope);
    phasor_entry = region2 && under_line;
  end
endmodule

// File: rtl/busdiff_satfsm.sv
`timescale 1ns/1ps
// Sealed-in three-state saturation detector with return timer
module busdiff_satfsm
  import busdiff_pkg::*;
#(
  parameter int TW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sample_vld,
  input  logic          phasor_entry,
  input  logic          didt_flag,
  input  logic          biased_pkp,
  input  logic [TW-1:0] ret_count,
  output sat_state_e    state_q,
  output sat_state_e    state_nxt,
  output logic          entry_evt,
  output logic          timeout_evt
);
  localparam int CW = TW + 1;

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] cnt_nxt;
  logic [CW-1:0] lim;

  always_comb begin
    lim         = (ret_count == '0) ? CW'(1) : {1'b0, ret_count};
    entry_evt   = phasor_entry || didt_flag;
    timeout_evt = !biased_pkp && (({1'b0, cnt_q} + CW'(1)) >= lim);
    state_nxt   = state_q;
    unique case (state_q)
      ST_NORMAL: if (entry_evt) state_nxt = ST_EXTF;
      ST_EXTF: begin
        if (biased_pkp)       state_nxt = ST_EXTSAT;
        else if (timeout_evt) state_nxt = ST_NORMAL;
      end
      ST_EXTSAT: if (timeout_evt) state_nxt = ST_NORMAL;
      default:   state_nxt = ST_NORMAL;
    endcase
    if (state_nxt == ST_NORMAL || biased_pkp) cnt_nxt = '0;
    else if (state_q == ST_NORMAL)            cnt_nxt = '0;
    else                                      cnt_nxt = cnt_q + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_NORMAL;
      cnt_q   <= '0;
    end else if (sample_vld) begin
      state_q <= state_nxt;
      cnt_q   <= cnt_nxt;
    end
  end
endmodule

// File: rtl/busdiff_tripgate.sv
`timescale 1ns/1ps
// Adaptive 1-out-of-2 / 2-out-of-2 trip supervision
module busdiff_tripgate (
  input  logic clk,
  input  logic rst_n,
  input  logic sample_vld,
  input  logic region2,
  input  logic sat_nxt,
  input  logic biased_pkp,
  input  logic unbiased_op,
  input  logic dir_ok,
  output logic mode_q,
  output logic trip_q
);
  logic need_dir;
  logic sup_trip;

  always_comb begin
    need_dir = !region2 || sat_nxt;
    sup_trip = biased_pkp && (dir_ok || !need_dir);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b1;
      trip_q <= 1'b0;
    end else if (sample_vld) begin
      mode_q <= need_dir;
      trip_q <= unbiased_op || sup_trip;
    end
  end
endmodule

// File: rtl/busdiff_satsup.sv
`timescale 1ns/1ps
module busdiff_satsup
  import busdiff_pkg::*;
#(
  parameter int W  = 16,
  parameter int SW = 8,
  parameter int TW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sample_vld,
  input  logic [W-1:0]  diff_mag,
  input  logic [W-1:0]  rest_mag,
  input  logic [SW-1:0] low_slope,
  input  logic [W-1:0]  high_bkpt,
  input  logic [TW-1:0] ret_count,
  input  logic          biased_pkp,
  input  logic          unbiased_op,
  input  logic          didt_flag,
  input  logic          dir_ok,
  output logic [1:0]    state_o,
  output logic          sat_flag,
  output logic          mode_2oo2,
  output logic          trip
);
  logic       region2;
  logic       under_line;
  logic       phasor_entry;
  logic       entry_evt;
  logic       timeout_evt;
  sat_state_e state_q;
  sat_state_e state_nxt;

  busdiff_opzone #(.W(W), .SW(SW)) u_zone (
    .diff_mag     (diff_mag),
    .rest_mag     (rest_mag),
    .low_slope    (low_slope),
    .high_bkpt    (high_bkpt),
    .region2      (region2),
    .under_line   (under_line),
    .phasor_entry (phasor_entry)
  );

  busdiff_satfsm #(.TW(TW)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .sample_vld   (sample_vld),
    .phasor_entry (phasor_entry),
    .didt_flag    (didt_flag),
    .biased_pkp   (biased_pkp),
    .ret_count    (ret_count),
    .state_q      (state_q),
    .state_nxt    (state_nxt),
    .entry_evt    (entry_evt),
    .timeout_evt  (timeout_evt)
  );

  busdiff_tripgate u_gate (
    .clk         (clk),
    .rst_n       (rst_n),
    .sample_vld  (sample_vld),
    .region2     (region2),
    .sat_nxt     (sat_of(state_nxt)),
    .biased_pkp  (biased_pkp),
    .unbiased_op (unbiased_op),
    .dir_ok      (dir_ok),
    .mode_q      (mode_2oo2),
    .trip_q      (trip)
  );

  assign state_o  = state_q;
  assign sat_flag = sat_of(state_q);
endmodule

// File: rtl/busdiff_satsup_chk.sv
`timescale 1ns/1ps
module busdiff_satsup_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sample_vld,
  input logic       phasor_entry,
  input logic       biased_pkp,
  input logic       unbiased_op,
  input logic       didt_flag,
  input logic       dir_ok,
  input logic       region2,
  input logic [1:0] state_o,
  input logic       sat_flag,
  input logic       mode_2oo2,
  input logic       trip
);
  p_enter_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_vld && state_o == 2'd0 && phasor_entry) |=> (state_o == 2'd1 && sat_flag));

  p_didt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_vld && state_o == 2'd0 && didt_flag) |=> sat_flag);

  p_ext_to_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_vld && state_o == 2'd1 && biased_pkp) |=> state_o == 2'd2);

  p_seal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_vld && sat_flag && biased_pkp) |=> sat_flag);

  p_no_pkp_no_trip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_vld && !unbiased_op && !biased_pkp) |=> !trip);

  p_region1_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_vld && !region2) |=> mode_2oo2);

  p_no_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_vld && biased_pkp && dir_ok) |=> trip);

  p_unbiased_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_vld && unbiased_op) |=> trip);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_vld |=> ($stable(trip) && $stable(state_o) && $stable(mode_2oo2) && $stable(sat_flag)));

  p_state_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
    state_o != 2'd3);
endmodule

bind busdiff_satsup busdiff_satsup_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sample_vld   (sample_vld),
  .phasor_entry (phasor_entry),
  .biased_pkp   (biased_pkp),
  .unbiased_op  (unbiased_op),
  .didt_flag    (didt_flag),
  .dir_ok       (dir_ok),
  .region2      (region2),
  .state_o      (state_o),
  .sat_flag     (sat_flag),
  .mode_2oo2    (mode_2oo2),
  .trip         (trip)
);

// File: tb/busdiff_satsup_bench.sv
`timescale 1ns/1ps
module busdiff_satsup_bench;
  localparam int W  = 16;
  localparam int SW = 8;
  localparam int TW = 12;
  localparam int NV = 20;

  typedef struct packed {
    logic [15:0] rest;
    logic [15:0] diff;
    logic        pkp;
    logic        unb;
    logic        didt;
    logic        dir;
    logic [1:0]  st;
    logic        trip;
    logic        mode;
  } vec_t;

  // Settings: slope 64/256, breakpoint 1000, return count 3.
  // Below the line means diff*4 < rest.
  localparam vec_t VEC [NV] = '{
    '{16'd500,  16'd10,  1'b0,1'b0,1'b0,1'b0, 2'd0,1'b0,1'b1}, // R3 R7 region 1, no entry
    '{16'd500,  16'd300, 1'b1,1'b0,1'b0,1'b0, 2'd0,1'b0,1'b1}, // R7 pickup without direction
    '{16'd500,  16'd300, 1'b1,1'b0,1'b0,1'b1, 2'd0,1'b1,1'b1}, // R7 pickup with direction
    '{16'd1000, 16'd10,  1'b0,1'b0,1'b0,1'b0, 2'd0,1'b0,1'b1}, // R3 restraint equals breakpoint
    '{16'd2000, 16'd500, 1'b0,1'b0,1'b0,1'b0, 2'd0,1'b0,1'b0}, // R3 exactly on slope line
    '{16'd2000, 16'd900, 1'b1,1'b0,1'b0,1'b0, 2'd0,1'b1,1'b0}, // R8 region 2, 1oo2
    '{16'd2000, 16'd100, 1'b0,1'b0,1'b0,1'b0, 2'd1,1'b0,1'b1}, // R2 entry
    '{16'd2000, 16'd900, 1'b1,1'b0,1'b0,1'b0, 2'd2,1'b0,1'b1}, // R5 R9 saturation, no direction
    '{16'd2000, 16'd900, 1'b1,1'b0,1'b0,1'b1, 2'd2,1'b1,1'b1}, // R9 not blocked
    '{16'd500,  16'd10,  1'b0,1'b0,1'b0,1'b0, 2'd2,1'b0,1'b1}, // R6 count 1
    '{16'd500,  16'd10,  1'b0,1'b0,1'b0,1'b0, 2'd2,1'b0,1'b1}, // R6 count 2
    '{16'd2000, 16'd900, 1'b1,1'b0,1'b0,1'b0, 2'd2,1'b0,1'b1}, // R6 restart
    '{16'd500,  16'd10,  1'b0,1'b0,1'b0,1'b0, 2'd2,1'b0,1'b1}, // R6 count 1
    '{16'd500,  16'd10,  1'b0,1'b0,1'b0,1'b0, 2'd2,1'b0,1'b1}, // R6 count 2
    '{16'd500,  16'd10,  1'b0,1'b0,1'b0,1'b0, 2'd0,1'b0,1'b1}, // R6 return
    '{16'd500,  16'd10,  1'b0,1'b0,1'b1,1'b0, 2'd1,1'b0,1'b1}, // R4 derivative entry
    '{16'd500,  16'd10,  1'b0,1'b1,1'b0,1'b0, 2'd1,1'b1,1'b1}, // R10 unrestrained
    '{16'd500,  16'd10,  1'b0,1'b0,1'b0,1'b0, 2'd1,1'b0,1'b1}, // R6 count 2
    '{16'd500,  16'd10,  1'b0,1'b0,1'b0,1'b0, 2'd0,1'b0,1'b1}, // R6 return from state 1
    '{16'd3000, 16'd2500,1'b1,1'b0,1'b0,1'b0, 2'd0,1'b1,1'b0}  // R8 region 2 trip alone
  };
  localparam string VTAG [NV] = '{"R3","R7","R7","R3","R3","R8","R2","R5","R9","R6",
                                  "R6","R6","R6","R6","R6","R4","R10","R6","R6","R8"};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sample_vld = 1'b0;
  logic [W-1:0]  diff_mag = '0;
  logic [W-1:0]  rest_mag = '0;
  logic [SW-1:0] low_slope = 8'd64;
  logic [W-1:0]  high_bkpt = 16'd1000;
  logic [TW-1:0] ret_count = 12'd3;
  logic          biased_pkp = 1'b0;
  logic          unbiased_op = 1'b0;
  logic          didt_flag = 1'b0;
  logic          dir_ok = 1'b0;
  logic [1:0]    state_o;
  logic          sat_flag;
  logic          mode_2oo2;
  logic          trip;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  busdiff_satsup #(.W(W), .SW(SW), .TW(TW)) u_busdiff_satsup (
    .clk(clk), .rst_n(rst_n), .sample_vld(sample_vld),
    .diff_mag(diff_mag), .rest_mag(rest_mag), .low_slope(low_slope),
    .high_bkpt(high_bkpt), .ret_count(ret_count), .biased_pkp(biased_pkp),
    .unbiased_op(unbiased_op), .didt_flag(didt_flag), .dir_ok(dir_ok),
    .state_o(state_o), .sat_flag(sat_flag), .mode_2oo2(mode_2oo2), .trip(trip)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [15:0] r, input logic [15:0] d, input logic p,
                       input logic u, input logic dd, input logic dr);
    rest_mag = r; diff_mag = d; biased_pkp = p;
    unbiased_op = u; didt_flag = dd; dir_ok = dr;
  endtask

  // Present one strobed sample, then sample outputs at the next falling edge
  task automatic step(input logic [15:0] r, input logic [15:0] d, input logic p,
                      input logic u, input logic dd, input logic dr);
    @(negedge clk);
    drive(r, d, p, u, dd, dr);
    sample_vld = 1'b1;
    @(negedge clk);
    sample_vld = 1'b0;
  endtask

  task automatic expect_out(input string tag, input int st, input int tr, input int md);
    check({tag, " state"}, state_o, st);
    check({tag, " sat"}, sat_flag, (st != 0) ? 1 : 0);
    check({tag, " trip"}, trip, tr);
    check({tag, " mode"}, mode_2oo2, md);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    expect_out("R1 in reset", 0, 0, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    expect_out("R1 after reset", 0, 0, 1);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i].rest, VEC[i].diff, VEC[i].pkp, VEC[i].unb, VEC[i].didt, VEC[i].dir);
      expect_out(VTAG[i], VEC[i].st, VEC[i].trip, VEC[i].mode);
    end

    // R11: inputs change with no strobe; last sample left trip=1, state 0, mode 0
    drive(16'd2000, 16'd100, 1'b0, 1'b0, 1'b1, 1'b0);
    repeat (4) @(negedge clk);
    expect_out("R11 hold", 0, 1, 0);

    // R6: return count of zero behaves as one sample
    ret_count = '0;
    step(16'd500, 16'd10, 1'b0, 1'b0, 1'b1, 1'b0);
    expect_out("R4 entry before zero count", 1, 0, 1);
    step(16'd500, 16'd10, 1'b0, 1'b0, 1'b0, 1'b0);
    expect_out("R6 zero count return", 0, 0, 1);

    // R10: unrestrained operate in region 2 after saturation, no direction
    ret_count = 12'd3;
    step(16'd2000, 16'd100, 1'b0, 1'b0, 1'b0, 1'b0);
    step(16'd2000, 16'd900, 1'b1, 1'b1, 1'b0, 1'b0);
    expect_out("R10 bypass in state 2", 2, 1, 1);

    // R1: reset while sealed in
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    expect_out("R1 mid-run reset", 0, 0, 1);
    rst_n = 1'b1;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule